// File: doc/BRIEF.md
# SDRAM Command and Refresh Controller

This block turns single-word read and write requests into the command sequence a 16-bit single-data-rate SDRAM needs. The memory has four banks, 8192 rows and 512 columns. A 24-bit flat word address is split as `{row[12:0], bank[1:0], col[8:0]}`. The controller keeps one open row per bank. A request that hits the open row goes straight to a column command. A request to a closed bank first activates the row. A request to another row of an open bank precharges that bank and then activates the new row. Every command, address, mask and write-data pin comes from a register. Read data is captured from the data bus after the programmed CAS latency, which is 2 or 3.

After reset the controller drives CKE high and waits a stable-clock delay. It then precharges all banks, issues two auto-refreshes and loads the mode register. A refresh interval timer raises a pending flag. When the current access has finished, the controller closes any open rows with a precharge-all, issues an auto-refresh, and waits tRFC before it accepts new work. All timing values are parameters counted in clock cycles.

States and transitions: POWERUP goes to INIT_PRE when the delay ends. INIT_PRE goes through WAIT to INIT_REF. INIT_REF runs twice, each time through WAIT, and then goes to LOAD_MODE. LOAD_MODE goes through WAIT to IDLE. IDLE goes to REF_PRE or REFRESH when a refresh is pending. Otherwise, on a request, it goes to ACTIVATE (bank closed), PRECHARGE (row miss), or READ / WRITE (row hit). PRECHARGE goes through WAIT to ACTIVATE. ACTIVATE goes through WAIT to READ or WRITE. READ, WRITE and REFRESH each go through WAIT back to IDLE. REF_PRE goes through WAIT to REFRESH.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held, CKE is low and the command pins carry NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1). From the first cycle after reset CKE is high.
- R2: After reset, no command other than NOP appears for at least T_INIT cycles. The first four commands are then, in order: PRECHARGE with A10=1 (all banks), AUTO-REFRESH, AUTO-REFRESH, and MODE REGISTER SET. Each of these is at least its own recovery time (tRP, tRFC, tMRD) after the one before it.
- R3: The mode register word on A[12:0] with BA=00 sets burst length 1 (A2:A0=000), sequential order (A3=0), and CAS latency CAS_LAT on A6:A4. All other bits are 0.
- R4: For address `{row,bank,col}`, ACTIVATE carries the row on A[12:0] and the bank on BA. READ and WRITE carry the column on A[8:0] and the same bank on BA, with A10=0.
- R5: A request to a row other than the one open in its bank issues a single-bank PRECHARGE (A10=0) and then an ACTIVATE at least tRP cycles later. An ACTIVATE is never issued to a bank that is already open.
- R6: A request to the row already open in its bank issues its READ or WRITE without any PRECHARGE or ACTIVATE.
- R7: A READ or WRITE comes at least tRCD cycles after the ACTIVATE of its bank.
- R8: Read data is sampled from the data bus CAS_LAT cycles after the memory samples the READ command. It then appears on rd_data, with rd_valid high for one cycle, one cycle later.
- R9: During a WRITE command cycle, and only then, the data output enable is high. The write data is on the bus and DQM equals the inverse of req_be (bit 0 is the low byte). A byte whose req_be bit is 0 keeps its old value. req_be=00 leaves the word unchanged.
- R10: An AUTO-REFRESH is issued at least once every T_REFI cycles plus the length of one access. When any row is open it is preceded by a precharge-all. No other command follows it within tRFC cycles.
- R11: req_ready is low during initialisation, while an access or refresh is in progress, and in the cycle after a request is accepted. While req_ready is high the command pins carry NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat word address {row, bank, col} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for a write, bit 0 = low byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row / column / mode address |
| sd_dqm | output | 2 | Byte masks, high masks the byte |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned by memory |

## Verification
The command pins show a command one cycle after its state. The memory samples it at the next edge. For a read, the data must be stable at the edge CAS_LAT cycles later, and rd_valid is visible just after that edge. The memory model numbers every rising edge. It records the edge at which it sees each READ, drives the data so it is stable at that edge plus CAS_LAT, and the scoreboard checks that rd_valid arrives at exactly that edge number. Command spacing is measured the same way, in edges between sampled commands. Each check is made against the tRCD, tRP, tRFC and tMRD minimums rather than against exact gaps. The only exceptions are the read latency and the refresh interval bound.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // Command encoding on {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_t;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_PRECHARGE,
        ST_ACTIVATE,
        ST_READ,
        ST_WRITE,
        ST_REF_PRE,
        ST_REFRESH,
        ST_WAIT
    } ctrl_state_t;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [ADDR_W-1:0] flat_addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);

    // Bank bits sit between row and column so that linear streams
    // rotate through banks before changing row.
    assign col  = flat_addr[COL_W-1:0];
    assign bank = flat_addr[COL_W +: BANK_W];
    assign row  = flat_addr[COL_W+BANK_W +: ROW_W];

endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_en,
    input  logic              close_en,
    input  logic              close_all,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit,
    output logic              any_open
);

    logic [BANKS-1:0]       open_vec;
    logic [BANKS*ROW_W-1:0] rows_flat;
    logic [ROW_W-1:0]       look_row_open;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] IDX = BANK_W'(b);
        logic             open_q;
        logic [ROW_W-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (close_all || (close_en && upd_bank == IDX)) begin
                open_q <= 1'b0;
            end else if (open_en && upd_bank == IDX) begin
                open_q <= 1'b1;
                row_q  <= upd_row;
            end
        end

        assign open_vec[b]                   = open_q;
        assign rows_flat[b*ROW_W +: ROW_W]   = row_q;
    end

    assign look_row_open = rows_flat[look_bank*ROW_W +: ROW_W];
    assign look_open     = open_vec[look_bank];
    assign look_hit      = look_open && (look_row_open == look_row);
    assign any_open      = |open_vec;

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int T_REFI = 780,
    localparam int CNT_W = $clog2(T_REFI + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ack,
    output logic due
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else if (enable) begin
            if (cnt_q == CNT_W'(T_REFI - 1)) begin
                cnt_q <= '0;
                due   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 9,
    parameter int DATA_W  = 16,
    parameter int T_INIT  = 20000,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 9,
    parameter int T_MRD   = 2,
    parameter int T_WR    = 2,
    parameter int T_REFI  = 780,
    parameter int CAS_LAT = 3,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    localparam int TMR_W     = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_MRD + T_WR + CAS_LAT + 2);
    localparam int INIT_REFS = 2;
    localparam int AP_BIT    = 10;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    ctrl_state_t       state_q, ret_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [1:0]        init_refs_q;
    logic              init_done_q;

    logic              wr_q;
    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [MASK_W-1:0] be_q;

    logic [ROW_W-1:0]  look_row;
    logic [BANK_W-1:0] look_bank;
    logic [COL_W-1:0]  look_col;
    logic              look_open, look_hit, any_open;
    logic              ref_due;

    // next-cycle pin values and side effects, from the output process
    sd_cmd_t           cmd_d, cmd_q;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  a_d;
    logic [MASK_W-1:0] dqm_d;
    logic              oe_d;
    logic              trk_open, trk_close, trk_close_all;
    logic              ref_ack, rd_issue;
    logic [CAS_LAT:0]  rd_sr_q;

    sdram_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
        .flat_addr (req_addr),
        .row       (look_row),
        .bank      (look_bank),
        .col       (look_col)
    );

    sdram_row_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .open_en   (trk_open),
        .close_en  (trk_close),
        .close_all (trk_close_all),
        .upd_bank  (bank_q),
        .upd_row   (row_q),
        .look_bank (look_bank),
        .look_row  (look_row),
        .look_open (look_open),
        .look_hit  (look_hit),
        .any_open  (any_open)
    );

    sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
        .clk    (clk),
        .rst    (rst),
        .enable (init_done_q),
        .ack    (ref_ack),
        .due    (ref_due)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_POWERUP;
            ret_q       <= ST_IDLE;
            tmr_q       <= TMR_W'(T_INIT - 1);
            init_refs_q <= '0;
            init_done_q <= 1'b0;
            wr_q        <= 1'b0;
            row_q       <= '0;
            bank_q      <= '0;
            col_q       <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
        end else begin
            unique case (state_q)
                ST_POWERUP: begin
                    if (tmr_q == '0) state_q <= ST_INIT_PRE;
                    else             tmr_q   <= tmr_q - 1'b1;
                end
                ST_INIT_PRE: begin
                    tmr_q   <= TMR_W'(T_RP - 2);
                    ret_q   <= ST_INIT_REF;
                    state_q <= ST_WAIT;
                end
                ST_INIT_REF: begin
                    tmr_q       <= TMR_W'(T_RFC - 2);
                    init_refs_q <= init_refs_q + 1'b1;
                    ret_q       <= (init_refs_q == 2'(INIT_REFS - 1)) ? ST_LOAD_MODE : ST_INIT_REF;
                    state_q     <= ST_WAIT;
                end
                ST_LOAD_MODE: begin
                    tmr_q       <= TMR_W'(T_MRD - 2);
                    ret_q       <= ST_IDLE;
                    init_done_q <= 1'b1;
                    state_q     <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        state_q <= any_open ? ST_REF_PRE : ST_REFRESH;
                    end else if (req_valid) begin
                        wr_q    <= req_write;
                        row_q   <= look_row;
                        bank_q  <= look_bank;
                        col_q   <= look_col;
                        wdata_q <= req_wdata;
                        be_q    <= req_be;
                        if (!look_open)    state_q <= ST_ACTIVATE;
                        else if (look_hit) state_q <= req_write ? ST_WRITE : ST_READ;
                        else               state_q <= ST_PRECHARGE;
                    end
                end
                ST_PRECHARGE: begin
                    tmr_q   <= TMR_W'(T_RP - 2);
                    ret_q   <= ST_ACTIVATE;
                    state_q <= ST_WAIT;
                end
                ST_ACTIVATE: begin
                    tmr_q   <= TMR_W'(T_RCD - 2);
                    ret_q   <= wr_q ? ST_WRITE : ST_READ;
                    state_q <= ST_WAIT;
                end
                ST_READ: begin
                    tmr_q   <= TMR_W'(CAS_LAT);
                    ret_q   <= ST_IDLE;
                    state_q <= ST_WAIT;
                end
                ST_WRITE: begin
                    tmr_q   <= TMR_W'(T_WR - 2);
                    ret_q   <= ST_IDLE;
                    state_q <= ST_WAIT;
                end
                ST_REF_PRE: begin
                    tmr_q   <= TMR_W'(T_RP - 2);
                    ret_q   <= ST_REFRESH;
                    state_q <= ST_WAIT;
                end
                ST_REFRESH: begin
                    tmr_q   <= TMR_W'(T_RFC - 2);
                    ret_q   <= ST_IDLE;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (tmr_q == '0) state_q <= ret_q;
                    else             tmr_q   <= tmr_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode: command for the next pin cycle and bookkeeping strobes
    always_comb begin
        cmd_d         = CMD_NOP;
        ba_d          = bank_q;
        a_d           = '0;
        dqm_d         = '0;
        oe_d          = 1'b0;
        trk_open      = 1'b0;
        trk_close     = 1'b0;
        trk_close_all = 1'b0;
        ref_ack       = 1'b0;
        rd_issue      = 1'b0;
        req_ready     = 1'b0;
        unique case (state_q)
            ST_INIT_PRE, ST_REF_PRE: begin
                cmd_d         = CMD_PRE;
                a_d[AP_BIT]   = 1'b1;
                trk_close_all = 1'b1;
            end
            ST_INIT_REF: cmd_d = CMD_REF;
            ST_REFRESH: begin
                cmd_d   = CMD_REF;
                ref_ack = 1'b1;
            end
            ST_LOAD_MODE: begin
                cmd_d = CMD_MRS;
                ba_d  = '0;
                a_d   = MODE_WORD;
            end
            ST_IDLE: req_ready = !ref_due;
            ST_PRECHARGE: begin
                cmd_d     = CMD_PRE;
                trk_close = 1'b1;
            end
            ST_ACTIVATE: begin
                cmd_d    = CMD_ACT;
                a_d      = row_q;
                trk_open = 1'b1;
            end
            ST_READ: begin
                cmd_d    = CMD_RD;
                a_d      = ROW_W'(col_q);
                rd_issue = 1'b1;
            end
            ST_WRITE: begin
                cmd_d = CMD_WR;
                a_d   = ROW_W'(col_q);
                dqm_d = ~be_q;
                oe_d  = 1'b1;
            end
            default: ;
        endcase
    end

    // Pin registers and read capture pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            sd_cke    <= 1'b0;
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            rd_sr_q   <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            sd_cke    <= 1'b1;
            cmd_q     <= cmd_d;
            sd_ba     <= ba_d;
            sd_addr   <= a_d;
            sd_dqm    <= dqm_d;
            sd_dq_out <= wdata_q;
            sd_dq_oe  <= oe_d;
            rd_sr_q   <= {rd_sr_q[CAS_LAT-1:0], rd_issue};
            rd_valid  <= rd_sr_q[CAS_LAT];
            if (rd_sr_q[CAS_LAT]) rd_data <= sd_dq_in;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk #(
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 9,
    parameter int T_MRD   = 2,
    parameter int CAS_LAT = 3
) (
    input logic clk,
    input logic rst,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n,
    input logic sd_dq_oe,
    input logic rd_valid,
    input logic req_ready
);

    localparam int CW = 16;

    logic [3:0]    pin_cmd;
    logic          is_nop, is_act, is_pre, is_ref, is_mrs, is_rd, is_wr;
    logic [CW-1:0] since_act, since_pre, since_ref, since_mrs;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop  = sd_cs_n || pin_cmd == 4'b0111;
    assign is_act  = pin_cmd == 4'b0011;
    assign is_pre  = pin_cmd == 4'b0010;
    assign is_ref  = pin_cmd == 4'b0001;
    assign is_mrs  = pin_cmd == 4'b0000;
    assign is_rd   = pin_cmd == 4'b0101;
    assign is_wr   = pin_cmd == 4'b0100;

    function automatic logic [CW-1:0] bump(input logic hit, input logic [CW-1:0] v);
        if (hit)           return CW'(1);
        if (v == '1)       return v;
        return v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '1;
            since_pre <= '1;
            since_ref <= '1;
            since_mrs <= '1;
        end else begin
            since_act <= bump(is_act, since_act);
            since_pre <= bump(is_pre, since_pre);
            since_ref <= bump(is_ref, since_ref);
            since_mrs <= bump(is_mrs, since_mrs);
        end
    end

    AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> since_act >= CW'(T_RCD)); // R7
    AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
        (is_act || is_ref) |-> since_pre >= CW'(T_RP)); // R5
    AST_RFC_GAP: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> since_ref >= CW'(T_RFC)); // R10
    AST_MRD_GAP: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> since_mrs >= CW'(T_MRD)); // R2
    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> is_wr); // R9
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(is_rd, CAS_LAT + 1)); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> is_nop); // R11

endmodule

bind sdram_ctrl sdram_ctrl_chk #(
    .T_RCD   (T_RCD),
    .T_RP    (T_RP),
    .T_RFC   (T_RFC),
    .T_MRD   (T_MRD),
    .CAS_LAT (CAS_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dq_oe  (sd_dq_oe),
    .rd_valid  (rd_valid),
    .req_ready (req_ready)
);

// File: tb/sdram_ctrl_tb.sv
module sdram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P_INIT = 25, P_RCD = 3, P_RP = 3, P_RFC = 7, P_MRD = 2;
    localparam int P_WR = 2, P_REFI = 300, P_CL = 3, REF_SLACK = 40;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0, rd_data, sd_dq_out, sd_dq_in = 16'hDEAD;
    logic [1:0]  req_be = '0, sd_ba, sd_dqm;
    logic rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [12:0] sd_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_ctrl #(.T_INIT(P_INIT), .T_RCD(P_RCD), .T_RP(P_RP), .T_RFC(P_RFC),
                 .T_MRD(P_MRD), .T_WR(P_WR), .T_REFI(P_REFI), .CAS_LAT(P_CL)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    int total = 0, bad = 0;
    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    int edge_n = 0, rel_edge = 0, last_ref = -1000, mrs_edge = -1, max_gap = 0;
    int ref_cnt = 0, n_act = 0, n_pre = 0, log_n = 0, first_edge = 0;
    logic [3:0]  log_cmd [4];
    logic        log_a10 [4];
    logic [12:0] mode_word = '0;
    bit          mopen [4];
    logic [12:0] mrow [4];
    int          last_act [4], last_pre [4];
    logic [15:0] mem [int];
    int          due_q [$];
    logic [15:0] dat_q [$];
    int          t0_q [$];
    bit          map_on = 0;
    logic [12:0] cur_row;
    logic [1:0]  cur_bank;
    logic [8:0]  cur_col;

    initial for (int i = 0; i < 4; i++) begin
        mopen[i] = 0; last_act[i] = -1000; last_pre[i] = -1000; mrow[i] = '0;
    end

    always @(posedge clk) begin
        logic [3:0] pc;
        int key;
        logic [15:0] w;
        edge_n++;
        pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst && !sd_cs_n && pc != C_NOP) begin
            if (log_n < 4) begin
                log_cmd[log_n] = pc; log_a10[log_n] = sd_addr[10];
                if (log_n == 0) first_edge = edge_n;
                log_n++;
            end
            if (pc != C_NOP) check(edge_n - last_ref >= P_RFC, "R10", "gap after refresh", edge_n - last_ref, P_RFC);
            case (pc)
                C_ACT: begin
                    check(!mopen[sd_ba], "R5", "activate to open bank", 1, 0);
                    check(edge_n - last_pre[sd_ba] >= P_RP, "R5", "precharge to activate gap", edge_n - last_pre[sd_ba], P_RP);
                    if (map_on) check(sd_addr == cur_row && sd_ba == cur_bank, "R4", "activate row/bank",
                                      {sd_ba, sd_addr}, {cur_bank, cur_row});
                    mopen[sd_ba] = 1; mrow[sd_ba] = sd_addr; last_act[sd_ba] = edge_n; n_act++;
                end
                C_RD, C_WR: begin
                    check(mopen[sd_ba], "R6", "column command to closed bank", 0, 1);
                    check(edge_n - last_act[sd_ba] >= P_RCD, "R7", "activate to column gap", edge_n - last_act[sd_ba], P_RCD);
                    if (map_on) check(sd_addr[8:0] == cur_col && sd_ba == cur_bank && !sd_addr[10], "R4",
                                      "column/bank", {sd_ba, sd_addr}, {cur_bank, 4'b0, cur_col});
                    key = int'({sd_ba, mrow[sd_ba], sd_addr[8:0]});
                    if (pc == C_WR) begin
                        check(sd_dq_oe, "R9", "output enable on write", sd_dq_oe, 1);
                        w = mem.exists(key) ? mem[key] : 16'h0000;
                        if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                        mem[key] = w;
                    end else begin
                        due_q.push_back(edge_n + P_CL - 1);
                        dat_q.push_back(mem.exists(key) ? mem[key] : 16'hBAD0);
                        t0_q.push_back(edge_n);
                    end
                end
                C_PRE: begin
                    if (sd_addr[10]) for (int b = 0; b < 4; b++) begin mopen[b] = 0; last_pre[b] = edge_n; end
                    else begin mopen[sd_ba] = 0; last_pre[sd_ba] = edge_n; n_pre++; end
                end
                C_REF: begin
                    check(!mopen[0] && !mopen[1] && !mopen[2] && !mopen[3], "R10", "refresh with open row", 1, 0);
                    if (mrs_edge >= 0) begin
                        if (edge_n - (ref_cnt == 0 ? mrs_edge : last_ref) > max_gap)
                            max_gap = edge_n - (ref_cnt == 0 ? mrs_edge : last_ref);
                        ref_cnt++;
                    end
                    last_ref = edge_n;
                end
                C_MRS: begin
                    mode_word = sd_addr; mrs_edge = edge_n;
                    check(sd_ba == 2'b00, "R3", "mode register bank", sd_ba, 0);
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        sd_dq_in = 16'hDEAD;
        if (due_q.size() > 0 && due_q[0] == edge_n) begin
            sd_dq_in = dat_q[0];
            void'(due_q.pop_front());
            void'(dat_q.pop_front());
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q [$];
    logic [15:0] shadow [int];

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) check(0, "R8", "unexpected read data", rd_data, 0);
            else check(rd_data == exp_q[0], "R8", "read data", rd_data, exp_q[0]);
            if (t0_q.size() > 0) begin
                check(edge_n == t0_q[0] + P_CL, "R8", "read latency edge", edge_n, t0_q[0] + P_CL);
                void'(t0_q.pop_front());
            end
            if (exp_q.size() > 0) void'(exp_q.pop_front());
        end
    end

    function automatic logic [23:0] mk(input int row, input int bank, input int col);
        return {13'(row), 2'(bank), 9'(col)};
    endfunction

    task automatic do_req(input bit wr, input logic [23:0] addr, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] old;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_row = addr[23:11]; cur_bank = addr[10:9]; cur_col = addr[8:0];
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d; req_be = be;
        if (wr) begin
            old = shadow.exists(int'(addr)) ? shadow[int'(addr)] : 16'h0000;
            if (be[0]) old[7:0]  = d[7:0];
            if (be[1]) old[15:8] = d[15:8];
            shadow[int'(addr)] = old;
        end else exp_q.push_back(shadow[int'(addr)]);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R11", "ready after accept", req_ready, 0);
        while (!req_ready || exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic sync_refresh();
        int r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        int a0, p0, r0;
        repeat (3) @(negedge clk);
        check(!sd_cke, "R1", "cke in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "command in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(!req_ready, "R11", "ready in reset", req_ready, 0);
        rst = 1'b0; rel_edge = edge_n;
        @(negedge clk);
        check(sd_cke, "R1", "cke after reset", sd_cke, 1);
        check(!req_ready, "R11", "ready during init", req_ready, 0);
        while (!req_ready) @(negedge clk);
        check(first_edge - rel_edge >= P_INIT, "R2", "power-up delay", first_edge - rel_edge, P_INIT);
        check(log_cmd[0] == C_PRE && log_a10[0], "R2", "first command precharge-all", {log_cmd[0], 3'b0, log_a10[0]}, {C_PRE, 4'b0001});
        check(log_cmd[1] == C_REF && log_cmd[2] == C_REF, "R2", "two refreshes", {log_cmd[1], log_cmd[2]}, {C_REF, C_REF});
        check(log_cmd[3] == C_MRS, "R2", "mode load fourth", log_cmd[3], C_MRS);
        check(mode_word == 13'(P_CL << 4), "R3", "mode word", mode_word, P_CL << 4);
        map_on = 1;

        // basic write / read, closed bank
        do_req(1, mk(5, 1, 10), 16'h1234, 2'b11);
        do_req(0, mk(5, 1, 10), 16'h0, 2'b00);

        // row hit, then row miss in the same bank
        sync_refresh();
        do_req(1, mk(5, 1, 20), 16'h5678, 2'b11);
        a0 = n_act; p0 = n_pre;
        do_req(1, mk(5, 1, 11), 16'hCAFE, 2'b11);
        check(n_act == a0 && n_pre == p0, "R6", "row hit activity", (n_act - a0) + (n_pre - p0), 0);
        do_req(0, mk(5, 1, 11), 16'h0, 2'b00);
        a0 = n_act; p0 = n_pre;
        do_req(1, mk(7, 1, 3), 16'hBEEF, 2'b11);
        check(n_act == a0 + 1 && n_pre == p0 + 1, "R5", "row miss precharge+activate",
              (n_act - a0) * 16 + (n_pre - p0), 17);
        do_req(0, mk(5, 1, 10), 16'h0, 2'b00);

        // other banks and address extremes
        do_req(1, mk(0, 0, 0), 16'h0A0A, 2'b11);
        do_req(1, mk(8191, 3, 511), 16'hF00D, 2'b11);
        do_req(1, mk(4096, 2, 256), 16'h7777, 2'b11);
        do_req(0, mk(8191, 3, 511), 16'h0, 2'b00);
        do_req(0, mk(0, 0, 0), 16'h0, 2'b00);
        do_req(0, mk(4096, 2, 256), 16'h0, 2'b00);

        // byte masks
        do_req(1, mk(7, 1, 3), 16'h11AA, 2'b01);
        do_req(0, mk(7, 1, 3), 16'h0, 2'b00);
        do_req(1, mk(7, 1, 3), 16'h22BB, 2'b10);
        do_req(0, mk(7, 1, 3), 16'h0, 2'b00);
        do_req(1, mk(7, 1, 3), 16'h3333, 2'b00);
        do_req(0, mk(7, 1, 3), 16'h0, 2'b00);

        // refresh while idle
        r0 = ref_cnt;
        repeat (1500) @(negedge clk);
        check(ref_cnt - r0 >= 1500 / P_REFI - 1, "R10", "refreshes while idle", ref_cnt - r0, 1500 / P_REFI - 1);

        // traffic across refresh points
        for (int i = 0; i < 40; i++) begin
            do_req(1, mk(i % 3, i % 4, i), 16'(i * 16'h0101 + 16'h5), 2'b11);
            do_req(0, mk(i % 3, i % 4, i), 16'h0, 2'b00);
        end
        check(max_gap <= P_REFI + REF_SLACK, "R10", "refresh interval", max_gap, P_REFI + REF_SLACK);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8", "outstanding reads", exp_q.size(), 0);
        finish_run();
    end

endmodule